// File: doc/BRIEF.md
# Staged Multi-Mode Word Shifter

This block moves the bits of a data word left or right by any distance from zero to one less than the word width. It does this in one pass through a chain of stages. Stage k either passes its input unchanged or moves it by 2^k places, and bit k of the shift amount makes that choice. The stage results add up to the full distance.

Every stage is a row of identical per-bit selectors. Each selector picks one of four values:
- the bit on its lower side,
- the bit on its upper side,
- its own bit,
- zero.

The bits that enter at the two edges of the word depend on the mode:
- zero, for a logical shift;
- the sign bit, for an arithmetic right shift;
- the bit that fell off the other end, for a rotate.

An enable input forces every selector to zero. The result is captured in an output register, which a synchronous active-high reset clears. Surrounding logic presents an operand, amount, direction and mode on one clock edge. It takes the result from `dout` after the next edge.

Top module: `wshift_top`

## Requirements
- R1: `dout` is a register. While `rst` is high at a rising edge, `dout` becomes all zeros. Otherwise `dout` takes the result of the inputs sampled at that edge, so the result appears one cycle after the inputs.
- R2: When `en` is 0 at an edge, the registered result is all zeros, whatever the data, amount, direction and mode are.
- R3: When `en` is 1 and `amt` is 0, the result equals `din` in every mode and in both directions.
- R4: In logical mode (`mode` = 2'b00), `dir_left` = 1 gives `din << amt` and `dir_left` = 0 gives `din >> amt`. Vacated positions are filled with 0.
- R5: In arithmetic mode (`mode` = 2'b01), a right shift (`dir_left` = 0) fills vacated upper positions with `din[W-1]`. A left shift gives the same result as the logical left shift.
- R6: In rotate mode (`mode` = 2'b10), bits leaving one end re-enter at the other end. `dir_left` = 1 rotates toward the MSB, `dir_left` = 0 rotates toward the LSB, and the number of 1 bits is preserved.
- R7: Mode code 2'b11 gives exactly the logical-mode result for the same inputs.
- R8: Every amount from 0 to W-1 is exact. Stage k shifts by 2^k when `amt[k]` is 1, so distances such as W-1 that need all stages at once come out correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears `dout` |
| en | input | 1 | 1 = shift, 0 = force zero result |
| din | input | W | Operand word |
| amt | input | $clog2(W) | Shift distance |
| dir_left | input | 1 | 1 = toward MSB, 0 = toward LSB |
| mode | input | 2 | 00 logical, 01 arithmetic, 10 rotate, 11 logical |
| dout | output | W | Registered result |

## Verification
The bench builds the block with W = 16, which gives four stages and a four-bit amount. Every distance from 0 to 15 is therefore reachable, including 15, which uses all four stages at once. Operands with the sign bit set and operands with it clear are swept across all amounts, both directions and all four mode codes. This exposes wrong edge fills at every stage boundary. The enable and reset cases use non-zero operands, so a selector that leaks data shows up at `dout`.

// File: rtl/wshift_pkg.sv
package wshift_pkg;
  typedef enum logic [1:0] {
    SHM_LOGIC = 2'b00,
    SHM_ARITH = 2'b01,
    SHM_ROTATE = 2'b10,
    SHM_SPARE = 2'b11
  } shm_e;
endpackage

// File: rtl/wshift_cell.sv
module wshift_cell (
  input  logic en,
  input  logic move,
  input  logic to_left,
  input  logic from_lo,
  input  logic from_hi,
  input  logic own,
  output logic y
);
  always_comb begin
    if (!en)          y = 1'b0;
    else if (!move)   y = own;
    else if (to_left) y = from_lo;
    else              y = from_hi;
  end
endmodule

// File: rtl/wshift_stage.sv
module wshift_stage #(
  parameter int W    = 16,
  parameter int DIST = 1
) (
  input  logic         en,
  input  logic         move,
  input  logic         to_left,
  input  logic         rot,
  input  logic         ari,
  input  logic [W-1:0] x,
  output logic [W-1:0] y
);
  logic [W-1:0] lo_v;
  logic [W-1:0] hi_v;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i - DIST >= 0) begin : g_lo_in
      assign lo_v[i] = x[i-DIST];
    end else begin : g_lo_edge
      assign lo_v[i] = rot ? x[i-DIST+W] : 1'b0;
    end
    if (i + DIST < W) begin : g_hi_in
      assign hi_v[i] = x[i+DIST];
    end else begin : g_hi_edge
      assign hi_v[i] = rot ? x[i+DIST-W] : (ari ? x[W-1] : 1'b0);
    end
    wshift_cell u_cell (
      .en      (en),
      .move    (move),
      .to_left (to_left),
      .from_lo (lo_v[i]),
      .from_hi (hi_v[i]),
      .own     (x[i]),
      .y       (y[i])
    );
  end
endmodule

// File: rtl/wshift_top.sv
module wshift_top #(
  parameter int W = 16,
  localparam int SW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          dir_left,
  input  logic [1:0]    mode,
  output logic [W-1:0]  dout
);
  import wshift_pkg::*;

  logic rot_sel;
  logic ari_sel;
  logic [W-1:0] tap [SW+1];

  assign rot_sel = (mode == SHM_ROTATE);
  assign ari_sel = (mode == SHM_ARITH);
  assign tap[0]  = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    wshift_stage #(.W(W), .DIST(1 << k)) u_stage (
      .en      (en),
      .move    (amt[k]),
      .to_left (dir_left),
      .rot     (rot_sel),
      .ari     (ari_sel),
      .x       (tap[k]),
      .y       (tap[k+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= tap[SW];
  end

  // R2
  en_off_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> dout == '0);

  // R3
  zero_amt_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (en && amt == '0) |=> dout == $past(din));

  // R6
  rot_popcount_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode == SHM_ROTATE) |=> $countones(dout) == $countones($past(din)));

  // R5
  ari_sign_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode == SHM_ARITH && !dir_left) |=> dout[W-1] == $past(din[W-1]));

  // R4
  log_left_lsb_chk: assert property (@(posedge clk) disable iff (rst)
    (en && mode == SHM_LOGIC && dir_left && amt != '0) |=> dout[0] == 1'b0);
endmodule

// File: tb/wshift_top_tb_top.sv
module wshift_top_tb_top;
  localparam int W  = 16;
  localparam int SW = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          en;
  logic [W-1:0]  din;
  logic [SW-1:0] amt;
  logic          dir_left;
  logic [1:0]    mode;
  logic [W-1:0]  dout;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  wshift_top #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .en(en), .din(din), .amt(amt),
    .dir_left(dir_left), .mode(mode), .dout(dout)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] x, int a, bit lft,
                                         logic [1:0] m, bit e);
    logic signed [W-1:0] sx;
    sx = x;
    if (!e) return '0;
    if (m == 2'b10) begin
      if (a == 0) return x;
      return lft ? ((x << a) | (x >> (W - a))) : ((x >> a) | (x << (W - a)));
    end
    if (lft) return x << a;
    if (m == 2'b01) return sx >>> a;
    return x >> a;
  endfunction

  task automatic check(logic [W-1:0] got, logic [W-1:0] exp, string req);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic step(bit e, logic [W-1:0] x, int a, bit lft, logic [1:0] m,
                      string req);
    logic [W-1:0] exp;
    en = e; din = x; amt = a[SW-1:0]; dir_left = lft; mode = m;
    exp = model(x, a, lft, m, e);
    @(negedge clk);
    check(dout, exp, req);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hang expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b1; din = 16'hBEEF; amt = 4'd3; dir_left = 1'b0;
    mode = 2'b00;
    @(negedge clk); @(negedge clk);
    check(dout, '0, "R1 reset");
    rst = 1'b0;

    // R1: one-cycle latency with directed cases
    step(1, 16'hC800, 2, 0, 2'b00, "R1 R4 logical right");
    step(1, 16'h0019, 2, 1, 2'b00, "R4 logical left");
    step(1, 16'hC800, 2, 0, 2'b01, "R5 arith right");
    step(1, 16'h8019, 2, 1, 2'b01, "R5 arith left");
    step(1, 16'h0019, 2, 0, 2'b10, "R6 rotate right");
    step(1, 16'h8019, 2, 1, 2'b10, "R6 rotate left");
    step(1, 16'hF0F0, 5, 0, 2'b11, "R7 spare right");
    step(1, 16'hF0F0, 5, 1, 2'b11, "R7 spare left");

    // R2: enable low forces zero
    step(0, 16'hFFFF, 0, 0, 2'b00, "R2 en off");
    step(0, 16'h8001, 7, 1, 2'b10, "R2 en off rotate");
    step(0, 16'h8000, 15, 0, 2'b01, "R2 en off arith");

    // R3: amount zero passes
    for (int m = 0; m < 4; m++)
      for (int d = 0; d < 2; d++)
        step(1, 16'hA5C3, 0, d[0], m[1:0], "R3 zero amount");

    // R8 sweep; R4 R5 R6 R7 by mode
    for (int p = 0; p < 4; p++) begin
      logic [W-1:0] pat;
      pat = (p == 0) ? 16'h8001 : (p == 1) ? 16'h7FFE :
            (p == 2) ? 16'hC35A : 16'h0001;
      for (int m = 0; m < 4; m++)
        for (int d = 0; d < 2; d++)
          for (int a = 0; a < W; a++)
            step(1, pat, a, d[0], m[1:0],
                 (m == 0) ? "R8 R4 sweep" : (m == 1) ? "R8 R5 sweep" :
                 (m == 2) ? "R8 R6 sweep" : "R8 R7 sweep");
    end

    for (int n = 0; n < 400; n++) begin
      logic [31:0] r;
      r = $urandom;
      step(r[20], r[15:0], int'(r[19:16]), r[21], r[23:22], "R8 random");
    end

    // R1: reset mid-run clears
    rst = 1'b1; din = 16'hFFFF; en = 1'b1; amt = '0;
    @(negedge clk);
    check(dout, '0, "R1 reset mid-run");
    rst = 1'b0;

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule